// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps processor time. A 64-bit time base counts up and a 32-bit decrementer counts down, and both move by one on the same tick. The tick has two possible sources, picked by `mode_i`. With `mode_i` low, the tick is a divide-by-16 of the core clock, and it runs only while the external pin `ext_tick_i` is high. With `mode_i` high, each rising edge on `ext_tick_i` gives one tick, so the pin acts as an external clock. The pin passes through a two-flop synchronizer before either source uses it.

Software writes to the block through a single write port. The port selects one of four targets: the low half of the time base, the high half of the time base, the decrementer, or the interrupt clear. A read request takes a snapshot of the whole time base and of the decrementer on one clock edge, so the 64-bit value read back never mixes two different counts. When the decrementer wraps from zero to all-ones, it sets a sticky interrupt request.

Top module: `timebase_unit`

## Requirements
- R1: Writing `wr_sel_i`=0 loads `wr_data_i` into time base bits 31:0, and `wr_sel_i`=1 loads bits 63:32. The half that is not written keeps its value.
- R2: A cycle with `rd_en_i` high copies the time base and the decrementer, as they stood before that clock edge, into `rd_tb_o` and `rd_dec_o`. These outputs change only on a cycle with `rd_en_i` high.
- R3: With `mode_i`=0, one tick occurs for every 16 core cycles in which the synchronized pin is high. While the pin is low, both registers hold their values and the prescaler keeps its partial count.
- R4: With `mode_i`=1, each rising edge of `ext_tick_i` gives exactly one tick. Holding the pin high gives no further ticks.
- R5: On each tick the time base rises by 1, carrying from bit 31 into bit 32, and in the same cycle the decrementer falls by 1.
- R6: A tick that moves the decrementer from 0 to all-ones sets `irq_o`. `irq_o` then stays high until it is cleared.
- R7: Writing `wr_sel_i`=3 clears `irq_o`. If a wrap happens in the same cycle as the clear, the set wins and `irq_o` stays high.
- R8: A write to the time base (`wr_sel_i`=0 or 1) or to the decrementer (`wr_sel_i`=2) in a tick cycle takes priority over the tick. The tick is dropped for the register being written, and a dropped decrementer tick cannot set `irq_o`.
- R9: Any change of `mode_i` resets the prescaler count to zero.
- R10: After reset the time base is 0, the decrementer is all-ones, and `irq_o`, `rd_tb_o` and `rd_dec_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Tick source: 0 = gated core/16, 1 = pin rising edges |
| ext_tick_i | input | 1 | External pin: enable in mode 0, clock in mode 1 |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Target: 0 TB low, 1 TB high, 2 decrementer, 3 clear interrupt |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Snapshot request |
| rd_tb_o | output | 64 | Captured time base |
| rd_dec_o | output | 32 | Captured decrementer |
| irq_o | output | 1 | Sticky decrementer interrupt request |

## Verification
A prescaler that counts wrongly, or that loses its partial count while the pin is low, makes the tick total wrong by one. This shows up in the very next snapshot taken after a gating window of known length. A lost carry between the two halves shows in `rd_tb_o[63:32]` at the first tick that crosses bit 31. A flaw in the wrap or in the write priority shows at `irq_o` one cycle after the colliding tick, and in the decrementer value captured by the next snapshot.

// File: rtl/tbu_pkg.sv
package tbu_pkg;
  typedef enum logic [1:0] {
    SEL_TB_LO   = 2'd0,
    SEL_TB_HI   = 2'd1,
    SEL_DEC     = 2'd2,
    SEL_IRQ_CLR = 2'd3
  } tbu_sel_e;
endpackage

// File: rtl/tbu_tick_gen.sv
module tbu_tick_gen #(
  parameter int PRE_DIV     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic pin_i,
  output logic pin_sync_o,
  output logic tick_o
);
  localparam int CNT_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   mode_q;
  logic [CNT_W-1:0]       pre_q;
  logic                   pin_s, rise, pre_last, mode_chg;

  assign pin_s    = sync_q[SYNC_STAGES-1];
  assign rise     = pin_s & ~last_q;
  assign pre_last = (pre_q == CNT_W'(PRE_DIV - 1));
  assign mode_chg = (mode_i != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      last_q <= pin_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      mode_q <= mode_i;
      if (mode_chg)              pre_q <= '0;
      else if (!mode_q && pin_s) pre_q <= pre_last ? '0 : pre_q + CNT_W'(1);
    end
  end

  // no tick in the cycle the source switches
  assign tick_o     = ~mode_chg & (mode_q ? rise : (pin_s & pre_last));
  assign pin_sync_o = pin_s;
endmodule

// File: rtl/tbu_timebase.sv
module tbu_timebase #(
  parameter int TB_W   = 64,
  parameter int DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic [TB_W/DATA_W-1:0] wr_i,
  input  logic [DATA_W-1:0]      data_i,
  output logic [TB_W-1:0]        tb_o
);
  localparam int NHALF = TB_W / DATA_W;

  logic [TB_W-1:0] tb_q, tb_inc;
  wire  [TB_W-1:0] tb_d;
  logic            any_wr;

  assign tb_inc = tb_q + TB_W'(1);
  assign any_wr = |wr_i;

  // any half write drops the tick for the whole register
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign tb_d[h*DATA_W +: DATA_W] =
      wr_i[h] ? data_i :
      any_wr  ? tb_q[h*DATA_W +: DATA_W] :
      tick_i  ? tb_inc[h*DATA_W +: DATA_W] :
                tb_q[h*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tb_q <= '0;
    else         tb_q <= tb_d;
  end

  assign tb_o = tb_q;
endmodule

// File: rtl/tbu_decrementer.sv
module tbu_decrementer #(
  parameter int DEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [DEC_W-1:0] data_i,
  input  logic             clr_i,
  output logic [DEC_W-1:0] dec_o,
  output logic             irq_o
);
  logic [DEC_W-1:0] dec_q;
  logic             irq_q, wrap;

  assign wrap = tick_i & ~load_i & (dec_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q <= '1;
      irq_q <= 1'b0;
    end else begin
      if (load_i)      dec_q <= data_i;
      else if (tick_i) dec_q <= dec_q - DEC_W'(1);
      if (wrap)        irq_q <= 1'b1;
      else if (clr_i)  irq_q <= 1'b0;
    end
  end

  assign dec_o = dec_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/timebase_unit.sv
module timebase_unit
  import tbu_pkg::*;
#(
  parameter int TB_W    = 64,
  parameter int DEC_W   = 32,
  parameter int DATA_W  = 32,
  parameter int PRE_DIV = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              ext_tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [TB_W-1:0]   rd_tb_o,
  output logic [DEC_W-1:0]  rd_dec_o,
  output logic              irq_o
);
  localparam int NHALF = TB_W / DATA_W;

  logic             tick, pin_sync;
  logic [NHALF-1:0] tb_wr;
  logic             dec_wr, irq_clr;
  logic [TB_W-1:0]  tb;
  logic [DEC_W-1:0] dec;

  for (genvar h = 0; h < NHALF; h++) begin : g_tb_wr
    assign tb_wr[h] = wr_en_i && (wr_sel_i == 2'(int'(SEL_TB_LO) + h));
  end
  assign dec_wr  = wr_en_i && (wr_sel_i == SEL_DEC);
  assign irq_clr = wr_en_i && (wr_sel_i == SEL_IRQ_CLR);

  tbu_tick_gen #(.PRE_DIV(PRE_DIV), .SYNC_STAGES(2)) u_tick (
    .clk_i, .rst_ni, .mode_i, .pin_i(ext_tick_i),
    .pin_sync_o(pin_sync), .tick_o(tick)
  );

  tbu_timebase #(.TB_W(TB_W), .DATA_W(DATA_W)) u_tb (
    .clk_i, .rst_ni, .tick_i(tick), .wr_i(tb_wr), .data_i(wr_data_i), .tb_o(tb)
  );

  tbu_decrementer #(.DEC_W(DEC_W)) u_dec (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(dec_wr),
    .data_i(wr_data_i[DEC_W-1:0]), .clr_i(irq_clr), .dec_o(dec), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_tb_o  <= '0;
      rd_dec_o <= '0;
    end else if (rd_en_i) begin
      rd_tb_o  <= tb;
      rd_dec_o <= dec;
    end
  end
endmodule

// File: rtl/tbu_chk.sv
module tbu_chk #(
  parameter int TB_W   = 64,
  parameter int DEC_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic              pin_sync,
  input logic              tick,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [TB_W-1:0]   tb,
  input logic [DEC_W-1:0]  dec,
  input logic              irq_o
);
  logic tb_wr_any, dec_wr, clr, wrap;
  assign tb_wr_any = wr_en_i && (wr_sel_i == 2'd0 || wr_sel_i == 2'd1);
  assign dec_wr    = wr_en_i && (wr_sel_i == 2'd2);
  assign clr       = wr_en_i && (wr_sel_i == 2'd3);
  assign wrap      = tick && !dec_wr && (dec == '0);

  AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick); // R4
  AST_HOLD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !pin_sync) |-> !tick); // R3
  AST_TB_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !tb_wr_any) |=> $stable(tb)); // R3
  AST_TB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !tb_wr_any) |=> tb == $past(tb) + TB_W'(1)); // R5
  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !dec_wr) |=> dec == $past(dec) - DEC_W'(1)); // R5
  AST_DEC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_wr |=> dec == $past(wr_data_i[DEC_W-1:0])); // R8
  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> irq_o); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr) |=> irq_o); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !wrap) |=> !irq_o); // R7
endmodule

bind timebase_unit tbu_chk #(.TB_W(TB_W), .DEC_W(DEC_W), .DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .mode_i, .pin_sync, .tick, .wr_en_i, .wr_sel_i,
  .wr_data_i, .tb, .dec, .irq_o
);

// File: tb/timebase_unit_tb_top.sv
`timescale 1ns/1ps
module timebase_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0, pin = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [63:0] rd_tb;
  logic [31:0] rd_dec;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  timebase_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ext_tick_i(pin),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_tb_o(rd_tb), .rd_dec_o(rd_dec), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic snap();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_high(input int n);
    @(negedge clk); pin = 1'b1;
    repeat (n) @(negedge clk);
    pin = 1'b0;
    idle(4);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pin = 1'b1; idle(4); pin = 1'b0; idle(16);
    end
  endtask

  task automatic mode_toggle();
    @(negedge clk); mode = 1'b1; idle(2); mode = 1'b0; idle(2);
  endtask

  task automatic t_reset();
    chk("R10 irq", {63'd0, irq}, 64'd0);
    chk("R10 rd_tb", rd_tb, 64'd0);
    chk("R10 rd_dec", {32'd0, rd_dec}, 64'd0);
    snap();
    chk("R10 tb", rd_tb, 64'd0);
    chk("R10 dec", {32'd0, rd_dec}, 64'hFFFF_FFFF);
  endtask

  task automatic t_load_read();
    wr(2'd0, 32'h89AB_CDEF); wr(2'd1, 32'h0123_4567); wr(2'd2, 32'h55);
    snap();
    chk("R1 full load", rd_tb, 64'h0123_4567_89AB_CDEF);
    chk("R2 dec read", {32'd0, rd_dec}, 64'h55);
    wr(2'd1, 32'hCAFE_0000);
    chk("R2 held without rd", rd_tb, 64'h0123_4567_89AB_CDEF);
    snap();
    chk("R1 high half only", rd_tb, 64'hCAFE_0000_89AB_CDEF);
  endtask

  task automatic t_prescale();
    wr(2'd0, 32'hFFFF_FFFE); wr(2'd1, 32'h12); wr(2'd2, 32'd100);
    mode_toggle();
    pin_high(160); snap();
    chk("R5 tb carry 10 ticks", rd_tb, 64'h13_0000_0008);
    chk("R5 dec 10 ticks", {32'd0, rd_dec}, 64'd90);
    pin_high(8); idle(20); snap();
    chk("R3 partial no tick", rd_tb, 64'h13_0000_0008);
    pin_high(8); snap();
    chk("R3 count kept over low", rd_tb, 64'h13_0000_0009);
    chk("R3 dec", {32'd0, rd_dec}, 64'd89);
  endtask

  task automatic t_mode_reset();
    pin_high(8);
    mode_toggle();
    pin_high(8); snap();
    chk("R9 prescaler cleared", rd_tb, 64'h13_0000_0009);
    pin_high(8); snap();
    chk("R9 full 16 after clear", rd_tb, 64'h13_0000_000A);
  endtask

  task automatic t_edge();
    @(negedge clk); mode = 1'b1; idle(2);
    wr(2'd0, 32'd0); wr(2'd1, 32'd0); wr(2'd2, 32'd1000);
    pulses(5); snap();
    chk("R4 five edges", rd_tb, 64'd5);
    chk("R4 dec", {32'd0, rd_dec}, 64'd995);
    pin_high(100); snap();
    chk("R4 level high one tick", rd_tb, 64'd6);
  endtask

  task automatic t_wrap();
    wr(2'd2, 32'd2);
    pulses(2); snap();
    chk("R6 no irq at zero", {63'd0, irq}, 64'd0);
    chk("R6 dec zero", {32'd0, rd_dec}, 64'd0);
    pulses(1); snap();
    chk("R6 irq on wrap", {63'd0, irq}, 64'd1);
    chk("R6 dec all ones", {32'd0, rd_dec}, 64'hFFFF_FFFF);
    pulses(1);
    chk("R6 sticky", {63'd0, irq}, 64'd1);
    wr(2'd3, 32'd0);
    chk("R7 cleared", {63'd0, irq}, 64'd0);
  endtask

  // write lands on the posedge where the synchronized rise ticks
  task automatic collide(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); pin = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    idle(4); pin = 1'b0; idle(16);
  endtask

  task automatic t_collide();
    wr(2'd1, 32'hA); wr(2'd0, 32'h10); wr(2'd2, 32'd50);
    collide(2'd0, 32'd5); snap();
    chk("R8 tb load wins", rd_tb, 64'hA_0000_0005);
    chk("R5 dec still ticks", {32'd0, rd_dec}, 64'd49);
    collide(2'd2, 32'd0); snap();
    chk("R8 dec load wins", {32'd0, rd_dec}, 64'd0);
    chk("R8 no irq from dropped tick", {63'd0, irq}, 64'd0);
    chk("R8 tb ticks", rd_tb, 64'hA_0000_0006);
    collide(2'd3, 32'd0);
    chk("R7 set beats clear", {63'd0, irq}, 64'd1);
    wr(2'd3, 32'd0);
    chk("R7 clear alone", {63'd0, irq}, 64'd0);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_load_read();
    t_prescale();
    t_mode_reset();
    t_edge();
    t_wrap();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule